// File: doc/BRIEF.md
# Two-Part Inter-Frame Deferral Timer

This block is the deferral engine of a 10 Mb/s CSMA/CD MAC. It times the quiet gap that must pass on the medium before a pending frame may go out, and it decides whether carrier activity seen during that gap makes the MAC back off or can be ignored. The gap is split in two. In the first part, carrier restarts the gap count. In the second part, carrier no longer affects the count, so a pending frame starts when the gap ends even if this causes a collision.

All timing advances on a bit-time tick. After the MAC's own transmission, gap timing begins only once the transmitter is idle and carrier is low. Carrier is then ignored for a fixed blinding window, which covers the transceiver's self-test burst. Carrier that arrives inside the window does not extend it. A control input can switch the gap after a transmission to a single part. In that mode any carrier seen after the blinding window restarts the gap until the gap completes. The gap after a received frame always keeps its two parts.

The MAC holds its transmit request high and receives a one-cycle grant when it may start. It answers by raising its transmit-busy flag. A deferring flag reports whether the gap is still being timed.

Top module: `ifg_defer`

## Requirements
- R1: After reset, the gap counts as already expired: `deferring` is 0 and `xmit_go` is 0.
- R2: With the gap expired, a rising `xmit_req` produces `xmit_go` on the first clock edge that samples it.
- R3: After a received frame, `xmit_go` is asserted on the (GAP_TICKS+1)-th edge that samples `carrier_sense` low, counting that first low edge as 1, with `bit_tick` high on every edge and `xmit_req` held high.
- R4: Carrier sampled while fewer than PART1_TICKS ticks of gap have elapsed clears the count. The full gap restarts from the next edge that samples carrier low.
- R5: Once PART1_TICKS ticks have elapsed (two-part mode), carrier does not affect the count. A pending request is granted when the full gap completes, even while carrier is high.
- R6: `xmit_go` lasts exactly one cycle, even while `xmit_req` stays high. It is only issued when `xmit_req` was high on the edge before.
- R7: After a transmission, the gap starts only on the first edge that samples both `xmit_busy` and `carrier_sense` low. With ticks on every edge, the grant follows GAP_TICKS+1 edges later, counting that edge as 1.
- R8: Carrier is ignored during the BLIND_TICKS ticks that follow the start of the post-transmit gap.
- R9: Carrier that appears inside the blinding window does not extend the window. Carrier in the first part of the gap after the window has closed restarts the gap.
- R10: With `post_tx_single_part` = 1, carrier seen after the blinding window restarts the post-transmit gap, even beyond PART1_TICKS.
- R11: `post_tx_single_part` has no effect on the gap after a received frame. Carrier in the second part is still ignored.
- R12: `deferring` is 1 while the gap is being timed, while a grant is outstanding and while the transmitter is busy. It is 0 once the gap has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One pulse per bit time; all intervals count these |
| carrier_sense | input | 1 | Carrier sense from the transceiver |
| xmit_busy | input | 1 | High while the MAC is transmitting |
| xmit_req | input | 1 | A frame is waiting to be sent |
| post_tx_single_part | input | 1 | 1 = the gap after a transmit uses a single part |
| xmit_go | output | 1 | One-cycle grant to start transmission |
| deferring | output | 1 | Gap is being timed or the channel is held |

## Verification
A wrong gap count or a wrong part boundary shows at the ports as a grant that arrives early or late by a number of edges. This error becomes visible at the end of the 96-tick gap, so the bench measures grant latency to the exact edge after each carrier event. A blinding window with the wrong length or restart rule changes which carrier pulses restart the gap. Pulses placed on both sides of the window boundary reveal this within one gap time. A stuck state machine shows as `deferring` with the wrong value, or as a grant that repeats, on the very next cycle. A cycle-level reference model run under random ticks, carrier bursts and transmit lengths catches these errors wherever they occur.

// File: rtl/ifg_defer_pkg.sv
package ifg_defer_pkg;

    // Channel state seen by the deferral controller
    typedef enum logic [1:0] {
        ST_GAP     = 2'd0,   // timing or holding the inter-frame gap
        ST_GRANTED = 2'd1,   // grant issued, waiting for transmitter
        ST_TX      = 2'd2    // own transmission or its trailing carrier
    } ifg_state_e;

    typedef struct packed {
        ifg_state_e st;
        logic       after_tx;   // current gap follows our own transmission
        logic       grant;      // registered grant pulse
    } ifg_ctrl_t;

endpackage

// File: rtl/ifg_gap_counter.sv
module ifg_gap_counter #(
    parameter int GAP_TICKS   = 96,
    parameter int PART1_TICKS = 60,
    localparam int CW         = $clog2(GAP_TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clr,
    output logic [CW-1:0] count,
    output logic          in_part1,
    output logic          done
);
    localparam logic [CW-1:0] GAP_END = CW'(GAP_TICKS);
    localparam logic [CW-1:0] P1_END  = CW'(PART1_TICKS);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (tick && (cnt_q != GAP_END))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= GAP_END;   // expired at reset
        else        cnt_q <= cnt_d;
    end

    assign count    = cnt_q;
    assign in_part1 = (cnt_q < P1_END);
    assign done     = (cnt_q == GAP_END);
endmodule

// File: rtl/ifg_blind_window.sv
module ifg_blind_window #(
    parameter int BLIND_TICKS = 40,
    localparam int BW         = $clog2(BLIND_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    input  logic kill,
    output logic active
);
    localparam logic [BW-1:0] LAST = BW'(BLIND_TICKS - 1);

    typedef struct packed {
        logic          act;
        logic [BW-1:0] cnt;
    } blind_t;

    blind_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (kill) begin
            w_d.act = 1'b0;
        end else if (start && !w_q.act) begin
            w_d.act = 1'b1;
            w_d.cnt = '0;
        end else if (w_q.act && tick) begin
            if (w_q.cnt == LAST) w_d.act = 1'b0;
            else                 w_d.cnt = w_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign active = w_q.act;
endmodule

// File: rtl/ifg_defer.sv
module ifg_defer
    import ifg_defer_pkg::*;
#(
    parameter int GAP_TICKS   = 96,
    parameter int PART1_TICKS = 60,
    parameter int BLIND_TICKS = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic carrier_sense,
    input  logic xmit_busy,
    input  logic xmit_req,
    input  logic post_tx_single_part,
    output logic xmit_go,
    output logic deferring
);
    localparam int CW = $clog2(GAP_TICKS + 1);

    ifg_ctrl_t     ctrl_d, ctrl_q;
    logic          gap_clr, gap_part1, gap_done;
    logic [CW-1:0] gap_cnt;
    logic          blind_start, blind_kill, blind_act;
    logic          crs_eff, st_gap, after_tx;

    ifg_gap_counter #(
        .GAP_TICKS  (GAP_TICKS),
        .PART1_TICKS(PART1_TICKS)
    ) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (bit_tick),
        .clr     (gap_clr),
        .count   (gap_cnt),
        .in_part1(gap_part1),
        .done    (gap_done)
    );

    ifg_blind_window #(
        .BLIND_TICKS(BLIND_TICKS)
    ) u_blind (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (bit_tick),
        .start (blind_start),
        .kill  (blind_kill),
        .active(blind_act)
    );

    // Carrier as seen by the deferral logic: masked during blinding
    assign crs_eff = carrier_sense & ~blind_act;

    always_comb begin
        ctrl_d       = ctrl_q;
        ctrl_d.grant = 1'b0;
        gap_clr      = 1'b0;
        blind_start  = 1'b0;
        blind_kill   = 1'b0;
        unique case (ctrl_q.st)
            ST_GAP: begin
                if (xmit_busy) begin
                    ctrl_d.st  = ST_TX;
                    gap_clr    = 1'b1;
                    blind_kill = 1'b1;
                end else if (gap_done && xmit_req) begin
                    ctrl_d.st    = ST_GRANTED;
                    ctrl_d.grant = 1'b1;
                end else if (crs_eff && (gap_part1 || gap_done ||
                             (ctrl_q.after_tx && post_tx_single_part))) begin
                    // activity counts as a receive: restart full gap
                    gap_clr         = 1'b1;
                    ctrl_d.after_tx = 1'b0;
                end
            end
            ST_GRANTED: begin
                gap_clr = 1'b1;
                if (xmit_busy) ctrl_d.st = ST_TX;
            end
            ST_TX: begin
                if (!xmit_busy && !carrier_sense) begin
                    ctrl_d.st       = ST_GAP;
                    ctrl_d.after_tx = 1'b1;
                    blind_start     = 1'b1;
                end else begin
                    gap_clr = 1'b1;
                end
            end
            default: begin
                ctrl_d.st = ST_GAP;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.st       <= ST_GAP;
            ctrl_q.after_tx <= 1'b0;
            ctrl_q.grant    <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign st_gap    = (ctrl_q.st == ST_GAP);
    assign after_tx  = ctrl_q.after_tx;
    assign xmit_go   = ctrl_q.grant;
    assign deferring = ~st_gap | ~gap_done;
endmodule

// File: rtl/ifg_defer_chk.sv
module ifg_defer_chk #(
    parameter int GAP_TICKS   = 96,
    parameter int PART1_TICKS = 60,
    localparam int CW         = $clog2(GAP_TICKS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          xmit_busy,
    input logic          xmit_req,
    input logic          post_tx_single_part,
    input logic          xmit_go,
    input logic          deferring,
    input logic          st_gap,
    input logic          after_tx,
    input logic          blind_act,
    input logic [CW-1:0] gap_cnt
);
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        xmit_go |=> !xmit_go);

    a_r6_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        xmit_go |-> $past(xmit_req));

    a_r12_busy_defers: assert property (@(posedge clk) disable iff (!rst_n)
        xmit_busy |=> deferring);

    // R5 and R11: second part never moves the count backwards
    a_r5_part2_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_gap && !xmit_busy && gap_cnt >= CW'(PART1_TICKS) &&
         gap_cnt < CW'(GAP_TICKS) && !(after_tx && post_tx_single_part))
        |=> gap_cnt >= $past(gap_cnt));

    a_r8_blind_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st_gap && blind_act && !xmit_busy && gap_cnt != '0) |=> gap_cnt != '0);
endmodule

bind ifg_defer ifg_defer_chk #(
    .GAP_TICKS  (GAP_TICKS),
    .PART1_TICKS(PART1_TICKS)
) u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .xmit_busy          (xmit_busy),
    .xmit_req           (xmit_req),
    .post_tx_single_part(post_tx_single_part),
    .xmit_go            (xmit_go),
    .deferring          (deferring),
    .st_gap             (st_gap),
    .after_tx           (after_tx),
    .blind_act          (blind_act),
    .gap_cnt            (gap_cnt)
);

// File: tb/ifg_defer_bench.sv
module ifg_defer_bench;
    localparam int GAP   = 96;
    localparam int PART1 = 60;
    localparam int BLIND = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b1;
    logic carrier_sense = 1'b0;
    logic xmit_busy = 1'b0;
    logic xmit_req = 1'b0;
    logic post_tx_single_part = 1'b0;
    logic xmit_go, deferring;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    bit cmp_en = 1'b0;

    always #2 clk = ~clk;

    ifg_defer #(.GAP_TICKS(GAP), .PART1_TICKS(PART1), .BLIND_TICKS(BLIND)) u_ifg_defer (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .carrier_sense(carrier_sense),
        .xmit_busy(xmit_busy), .xmit_req(xmit_req),
        .post_tx_single_part(post_tx_single_part),
        .xmit_go(xmit_go), .deferring(deferring));

    // ---------------- reference model (from requirements) ----------------
    int m_cnt = GAP, m_st = 0, m_bcnt = 0;
    bit m_after = 0, m_bact = 0, m_grant = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = GAP; m_st = 0; m_after = 0; m_bact = 0; m_bcnt = 0; m_grant = 0;
        end else begin
            bit crs_e, clr, start, kill;
            crs_e = carrier_sense && !m_bact;
            clr = 0; start = 0; kill = 0; m_grant = 0;
            if (m_st == 0) begin
                if (xmit_busy) begin m_st = 2; clr = 1; kill = 1; end
                else if (m_cnt == GAP && xmit_req) begin m_st = 1; m_grant = 1; end
                else if (crs_e && (m_cnt < PART1 || m_cnt == GAP ||
                                   (m_after && post_tx_single_part))) begin
                    clr = 1; m_after = 0;
                end
            end else if (m_st == 1) begin
                clr = 1;
                if (xmit_busy) m_st = 2;
            end else begin
                if (!xmit_busy && !carrier_sense) begin m_st = 0; m_after = 1; start = 1; end
                else clr = 1;
            end
            if (clr) m_cnt = 0;
            else if (bit_tick && m_cnt < GAP) m_cnt++;
            if (kill) m_bact = 0;
            else if (start && !m_bact) begin m_bact = 1; m_bcnt = 0; end
            else if (m_bact && bit_tick) begin
                if (m_bcnt == BLIND - 1) m_bact = 0; else m_bcnt++;
            end
        end
    end

    function automatic bit exp_defer();
        return (m_st != 0) || (m_cnt != GAP);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            check(xmit_go == m_grant, "R6 random grant", int'(xmit_go), int'(m_grant));
            check(deferring == exp_defer(), "R12 random deferring",
                  int'(deferring), int'(exp_defer()));
        end
    end

    // ---------------- directed helpers ----------------
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; carrier_sense = 0; xmit_busy = 0; xmit_req = 0; bit_tick = 1;
        post_tx_single_part = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_grant(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!xmit_go && n < 400);
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    // receive: carrier for a while, then drop with request pending
    task automatic rx_frame();
        carrier_sense = 1; idle(10);
        carrier_sense = 0; xmit_req = 1;
    endtask

    // own transmission; returns with busy just dropped (carrier low)
    task automatic tx_frame();
        int n;
        xmit_req = 1;
        wait_grant(n);
        xmit_busy = 1; xmit_req = 0;
        idle(20);
        xmit_busy = 0; xmit_req = 1;
    endtask

    int n, glitch;

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        @(negedge clk);
        check(xmit_go == 0, "R1 grant after reset", int'(xmit_go), 0);
        check(deferring == 0, "R1 deferring after reset", int'(deferring), 0);

        // R2: immediate grant
        xmit_req = 1; wait_grant(n);
        check(n == 1, "R2 first grant latency", n, 1);
        // R6: single cycle with request still high
        @(negedge clk);
        check(xmit_go == 0, "R6 grant one cycle", int'(xmit_go), 0);
        check(deferring == 1, "R12 deferring while granted", int'(deferring), 1);

        // R3: receive gap
        do_reset(); rx_frame(); wait_grant(n);
        check(n == GAP + 1, "R3 receive gap latency", n, GAP + 1);

        // R4: carrier in first part restarts
        do_reset(); rx_frame(); xmit_req = 1;
        glitch = 0;
        repeat (30) begin @(negedge clk); if (xmit_go) glitch++; end
        carrier_sense = 1; @(negedge clk); carrier_sense = 0;
        wait_grant(n);
        check(glitch == 0, "R4 no early grant", glitch, 0);
        check(n == GAP + 1, "R4 restart latency", n, GAP + 1);

        // R5: carrier in second part ignored, grant despite carrier
        do_reset(); rx_frame(); idle(70);
        carrier_sense = 1; wait_grant(n);
        check(n == GAP + 1 - 70, "R5 part2 carrier ignored", n, GAP + 1 - 70);
        carrier_sense = 0;

        // R12: deferring drops exactly when gap completes
        do_reset(); rx_frame(); xmit_req = 0; idle(GAP - 1);
        check(deferring == 1, "R12 deferring before end", int'(deferring), 1);
        @(negedge clk);
        check(deferring == 0, "R12 deferring at end", int'(deferring), 0);

        // R7: gap starts only when busy and carrier both low
        do_reset(); tx_frame(); carrier_sense = 1; idle(15);
        carrier_sense = 0; wait_grant(n);
        check(n == GAP + 1, "R7 post-tx gap latency", n, GAP + 1);

        // R8: carrier inside blinding ignored
        do_reset(); tx_frame(); idle(30);
        carrier_sense = 1; @(negedge clk); carrier_sense = 0;
        wait_grant(n);
        check(n == GAP + 1 - 31, "R8 blinded carrier ignored", n, GAP + 1 - 31);

        // R9: blinding not extended; carrier after window restarts
        do_reset(); tx_frame(); idle(19);
        carrier_sense = 1; @(negedge clk); carrier_sense = 0;
        idle(25);
        carrier_sense = 1; @(negedge clk); carrier_sense = 0;
        wait_grant(n);
        check(n == GAP + 1, "R9 restart after window", n, GAP + 1);

        // R10: single-part after transmit, carrier beyond part 1 restarts
        do_reset(); post_tx_single_part = 1; tx_frame(); idle(70);
        carrier_sense = 1; @(negedge clk); carrier_sense = 0;
        wait_grant(n);
        check(n == GAP + 1, "R10 single part restart", n, GAP + 1);

        // R11: single-part bit does not touch receive gap
        do_reset(); post_tx_single_part = 1; rx_frame(); idle(70);
        carrier_sense = 1; @(negedge clk); carrier_sense = 0;
        wait_grant(n);
        check(n == GAP + 1 - 71, "R11 receive keeps two parts", n, GAP + 1 - 71);

        // ---------------- random phase against model ----------------
        do_reset();
        @(negedge clk);
        cmp_en = 1'b1;
        for (int cyc = 0; cyc < 40000; cyc++) begin
            bit_tick = ($urandom % 3) != 0;
            if (xmit_go) begin
                xmit_busy = 1; xmit_req = 0;
            end else if (xmit_busy) begin
                if ($urandom % 25 == 0) xmit_busy = 0;
            end else if (!xmit_req && ($urandom % 60 == 0)) begin
                xmit_req = 1;
            end
            if (carrier_sense) begin
                if ($urandom % 12 == 0) carrier_sense = 0;
            end else if ($urandom % 90 == 0) begin
                carrier_sense = 1;
            end
            if ($urandom % 2000 == 0) post_tx_single_part = ~post_tx_single_part;
            @(negedge clk);
        end
        cmp_en = 1'b0;

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 190000);
        if (!finished) begin
            finished = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule